// File: doc/BRIEF.md
# Interval Timer with Square-Wave Output

This block is an interval timer built around a small up-counter. While its run bit is high, every system clock that carries a count strobe advances the counter by one. When the counter has reached the value held on the compare input, the next strobe returns it to zero. On that same strobe the square-wave output changes level and a one-cycle interrupt pulse is raised.

For a compare value N the interrupt therefore arrives every N+1 strobes, and the square wave has a period of 2×(N+1) strobes. Dropping the run bit stops the timer, returns the counter to zero, and drives both the interrupt and the square wave to their inactive low level. The compare value may be changed at any time. The new value is used at the next comparison and never alters the counter.

All outputs are registered. Each one reflects the inputs sampled at the previous rising edge of the system clock.

Top module: `itvl_sqw_timer`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the next cycle shows count 00H, square-wave output low and interrupt low.
- R2: With run high, an edge that sees the strobe while count differs from the compare value raises count by one. The first strobe after run is set moves count from 00H to 01H.
- R3: With run high, an edge that sees the strobe while count equals the compare value produces, in the next cycle, count 00H, the square-wave level inverted, and the interrupt high. The interrupt falls again after that one cycle unless another match strobe follows.
- R4: With a fixed compare value N, interrupt pulses are N+1 strobes apart, and the square wave changes level once every N+1 strobes.
- R5: An edge that sees run low forces count to 00H, the square-wave output low and the interrupt low in the next cycle. These values are kept for as long as run stays low, whatever level they had before.
- R6: Strobes that arrive while run is low have no effect. While running, an edge without a strobe keeps count and the square-wave level, and leaves the interrupt low.
- R7: A change of the compare value leaves count untouched and is used from the next strobe on. Raising it above the current count lets counting continue past the old value.
- R8: Matching is by equality only. If the compare value is lowered below the current count, the counter runs on to FFH and wraps to 00H with no interrupt and no level change. It then counts up to the new value and matches there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count strobe, one system clock wide per count |
| run | input | 1 | Run enable; low stops and clears the timer |
| cmp_val | input | CNT_W | Compare value (N) |
| count | output | CNT_W | Current counter value |
| sq_out | output | 1 | Square-wave output level |
| irq | output | 1 | Interval interrupt pulse |

## Verification
The bench aims at the clear-on-match edge. A design that compared one step too late or too early would show intervals of N+2 or N strobes, and one that pulsed the interrupt a cycle off the clear would miss the cycle where count reads 00H. It also drops run while the square wave is high. A design that only stopped counting would leave the wave stuck high. Finally it lowers the compare value below the running count. A design that matched with "greater or equal" would fire at once instead of wrapping through FFH, and one that reloaded the counter on a compare write would show a count jump.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    // What the timer does at one clock edge
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,   // stopped: clear everything
        ACT_HOLD = 2'd1,   // running, no strobe
        ACT_STEP = 2'd2,   // running, strobe, no match
        ACT_WRAP = 2'd3    // running, strobe, match
    } act_e;

    typedef struct packed {
        logic run;
        logic tick;
        logic hit;
    } ctl_t;

    function automatic act_e decode_act(input ctl_t c);
        act_e a;
        if (!c.run)
            a = ACT_IDLE;
        else if (!c.tick)
            a = ACT_HOLD;
        else if (c.hit)
            a = ACT_WRAP;
        else
            a = ACT_STEP;
        return a;
    endfunction

endpackage

// File: rtl/itimer_match.sv
module itimer_match #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             hit
);
    always_comb hit = (count == cmp_val);
endmodule

// File: rtl/itimer_cnt.sv
module itimer_cnt
    import itimer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= ZERO;
        end else begin
            unique case (act)
                ACT_IDLE: count <= ZERO;
                ACT_WRAP: count <= ZERO;
                ACT_STEP: count <= count + ONE;
                default:  count <= count;
            endcase
        end
    end
endmodule

// File: rtl/itimer_wave.sv
module itimer_wave
    import itimer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  act_e act,
    output logic sq_out,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst || act == ACT_IDLE) begin
            sq_out <= 1'b0;
            irq    <= 1'b0;
        end else if (act == ACT_WRAP) begin
            sq_out <= ~sq_out;
            irq    <= 1'b1;
        end else begin
            irq    <= 1'b0;
        end
    end
endmodule

// File: rtl/itvl_sqw_timer.sv
module itvl_sqw_timer
    import itimer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             sq_out,
    output logic             irq
);
    logic hit;
    ctl_t ctl;
    act_e act;

    itimer_match #(.CNT_W(CNT_W)) u_match (
        .count   (count),
        .cmp_val (cmp_val),
        .hit     (hit)
    );

    always_comb begin
        ctl.run  = run;
        ctl.tick = tick;
        ctl.hit  = hit;
        act      = decode_act(ctl);
    end

    itimer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .count (count)
    );

    itimer_wave u_wave (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .sq_out (sq_out),
        .irq    (irq)
    );
endmodule

// File: rtl/itvl_sqw_timer_chk.sv
module itvl_sqw_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             run,
    input logic [CNT_W-1:0] cmp_val,
    input logic [CNT_W-1:0] count,
    input logic             sq_out,
    input logic             irq
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (count == '0) && !sq_out && !irq); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(run) && $past(tick) && ($past(count) != $past(cmp_val))
        |-> count == CNT_W'($past(count) + 1'b1)); // R2

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq |-> (count == '0) && (sq_out != $past(sq_out))); // R3

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count == '0) && !sq_out && !irq); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(run) && !$past(tick) |-> $stable(count) && $stable(sq_out) && !irq); // R6

    AST_WAVE_ONLY_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(run) && !irq |-> $stable(sq_out)); // R8
endmodule

bind itvl_sqw_timer itvl_sqw_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (run),
    .cmp_val (cmp_val),
    .count   (count),
    .sq_out  (sq_out),
    .irq     (irq)
);

// File: tb/itvl_sqw_timer_tb.sv
module itvl_sqw_timer_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         tick;
    logic         run;
    logic [W-1:0] cmp_val;
    logic [W-1:0] count;
    logic         sq_out;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    itvl_sqw_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .cmp_val(cmp_val),
        .count(count), .sq_out(sq_out), .irq(irq)
    );

    typedef struct packed {
        logic         run;
        logic         tick;
        logic [W-1:0] cmp;
        logic [W-1:0] e_cnt;
        logic         e_sq;
        logic         e_irq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'd3, 8'd0, 1'b0, 1'b0},  // R6 running, no strobe
        '{1'b1, 1'b1, 8'd3, 8'd1, 1'b0, 1'b0},  // R2 first strobe
        '{1'b1, 1'b1, 8'd3, 8'd2, 1'b0, 1'b0},  // R2
        '{1'b1, 1'b0, 8'd3, 8'd2, 1'b0, 1'b0},  // R6 hold
        '{1'b1, 1'b1, 8'd3, 8'd3, 1'b0, 1'b0},  // R2
        '{1'b1, 1'b1, 8'd3, 8'd0, 1'b1, 1'b1},  // R3 match
        '{1'b1, 1'b0, 8'd3, 8'd0, 1'b1, 1'b0},  // R3 pulse ends
        '{1'b1, 1'b1, 8'd3, 8'd1, 1'b1, 1'b0},  // R2
        '{1'b1, 1'b1, 8'd3, 8'd2, 1'b1, 1'b0},  // R2
        '{1'b1, 1'b1, 8'd3, 8'd3, 1'b1, 1'b0},  // R2
        '{1'b1, 1'b1, 8'd3, 8'd0, 1'b0, 1'b1},  // R3 second match
        '{1'b1, 1'b1, 8'd3, 8'd1, 1'b0, 1'b0},  // R2
        '{1'b0, 1'b1, 8'd3, 8'd0, 1'b0, 1'b0},  // R5 stop
        '{1'b0, 1'b1, 8'd3, 8'd0, 1'b0, 1'b0},  // R6 strobe ignored
        '{1'b1, 1'b1, 8'd3, 8'd1, 1'b0, 1'b0},  // R2 restart
        '{1'b1, 1'b1, 8'd1, 8'd0, 1'b1, 1'b1},  // R7 new compare hit
        '{1'b0, 1'b0, 8'd1, 8'd0, 1'b0, 1'b0}   // R5 wave forced low
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic t, input logic [W-1:0] c);
        run = r; tick = t; cmp_val = c;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1; run = 1'b0; tick = 1'b0; cmp_val = '0;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int gap;
        int last;
        int toggles;
        bit seen_irq;
        logic prev_sq;

        // R1 reset state
        rst = 1'b1; run = 1'b1; tick = 1'b1; cmp_val = 8'd2;
        repeat (3) @(posedge clk);
        #2;
        check("R1 count", count, 0);
        check("R1 sq", sq_out, 0);
        check("R1 irq", irq, 0);
        rst = 1'b0; run = 1'b0; tick = 1'b0;
        step(1'b0, 1'b0, 8'd3);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].run, VEC[i].tick, VEC[i].cmp);
            check($sformatf("R2/R3/R5/R6/R7 vec%0d count", i), count, VEC[i].e_cnt);
            check($sformatf("R3/R5 vec%0d sq", i), sq_out, VEC[i].e_sq);
            check($sformatf("R3/R5 vec%0d irq", i), irq, VEC[i].e_irq);
        end

        // R1 reset during a run with the wave high
        do_reset();
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'd2);
        check("R1 pre sq", sq_out, 1);
        rst = 1'b1;
        step(1'b1, 1'b1, 8'd2);
        check("R1 mid count", count, 0);
        check("R1 mid sq", sq_out, 0);
        rst = 1'b0;

        // R4 interval, strobe every cycle, N=5
        do_reset();
        last = -1; gap = 0; toggles = 0;
        prev_sq = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b1, 8'd5);
            if (sq_out != prev_sq) toggles++;
            prev_sq = sq_out;
            if (irq) begin
                if (last >= 0) gap = i - last;
                last = i;
            end
        end
        check("R4 gap N=5", gap, 6);
        check("R4 toggles N=5", toggles, 40 / 6);

        // R4 interval, strobe every other cycle, N=0xFE
        do_reset();
        last = -1; gap = 0;
        for (int i = 0; i < 1200; i++) begin
            step(1'b1, (i % 2) == 0, 8'hFE);
            if (irq) begin
                if (last >= 0) gap = i - last;
                last = i;
            end
        end
        check("R4 gap N=FE", gap, 2 * 255);

        // R7 raise compare above count
        do_reset();
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'd3);
        step(1'b1, 1'b0, 8'd9);
        check("R7 count kept", count, 3);
        step(1'b1, 1'b1, 8'd9);
        check("R7 passes old value", count, 4);
        check("R7 no irq", irq, 0);

        // R8 lower compare below count
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 8'd10);
        step(1'b1, 1'b0, 8'd4);
        check("R7 count kept on write", count, 8);
        seen_irq = 1'b0;
        for (int i = 0; i < 248; i++) begin
            step(1'b1, 1'b1, 8'd4);
            if (irq) seen_irq = 1'b1;
        end
        check("R8 wrap count", count, 0);
        check("R8 no irq on wrap", seen_irq, 0);
        check("R8 no toggle on wrap", sq_out, 0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'd4);
        check("R8 reaches new value", count, 4);
        step(1'b1, 1'b1, 8'd4);
        check("R8 match count", count, 0);
        check("R8 match irq", irq, 1);
        check("R8 match sq", sq_out, 1);

        summary();
    end
endmodule